// File: doc/BRIEF.md
# Single-Cycle RISC Processor Core

This block is a small 32-bit processor that finishes one instruction on every rising clock edge. It runs register-to-register add, subtract, and, or and signed set-less-than, along with word load, word store and branch-if-equal. The core holds the program counter, a 32 x 32-bit register file with two read ports and one write port, the ALU, the sign extender and the operand and writeback selectors.

Decoding happens in two steps. A main decoder looks at the opcode and produces the datapath controls plus a 2-bit ALU class. A second decoder combines that class with the function field to choose the 3-bit ALU operation. The next PC comes from one of two adders. One adder produces the sequential address. The other produces the branch target. The target is taken only when the branch control and the ALU zero flag are both high.

Instruction memory and data memory are word-addressed arrays inside the block. While reset is held, a loader port fills them. A separate peek port reads data memory at any time, so results can be observed from outside the core.

Top module: `sc_core`

## Requirements
- R1: Reset is synchronous. While `rst` is high at a rising edge, the PC becomes 0, and `pc_o` reads 0 in the cycle after that edge.
- R2: Opcode 000000 is register format. The result of rs OP rt is written to register rd (bits [15:11]). Funct 100000 selects add, 100010 selects subtract, 100100 selects and, 100101 selects or, and 101010 selects set-less-than. Set-less-than compares the operands as signed values and writes 1 or 0.
- R3: Register 0 always reads as zero, and any write to it is discarded.
- R4: Opcode 100011 is load word. Register rt (bits [20:16]) receives the data word at byte address rs + sign-extended offset [15:0]. The memory word index is address bits [AW+1:2].
- R5: Opcode 101011 is store word. The store writes register rt to the data word at rs + sign-extended offset and writes no register. Only this opcode writes data memory.
- R6: Opcode 000100 is branch-if-equal. When rs equals rt, the next PC is PC+4 + (sign-extended offset << 2). When they differ, the next PC is PC+4. Every other instruction advances the PC by 4.
- R7: Any opcode other than the four above writes no register and no memory, and advances the PC by 4.
- R8: While `rst` is high, the loader port writes instruction memory (`ld_dmem`=0) or data memory (`ld_dmem`=1) at word index `ld_addr`. The core's own memory writes are blocked during reset.
- R9: `peek_data` shows the data-memory word at index `peek_addr` combinationally.
- R10: Negative offsets sign-extend. A negative load/store offset addresses below the base register, and a negative branch offset jumps backward. An offset of -1 makes a branch loop on itself.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset; also enables the loader |
| ld_we | input | 1 | Loader write strobe (effective only in reset) |
| ld_dmem | input | 1 | Loader target: 0 instruction memory, 1 data memory |
| ld_addr | input | LD_AW | Loader word index |
| ld_data | input | 32 | Loader write word |
| peek_addr | input | DMEM_AW | Data-memory word index to observe |
| peek_data | output | 32 | Data-memory word at `peek_addr` |
| pc_o | output | 32 | Current program counter |

## Verification
The assertions assume the loader is driven only during reset. They also assume every program is made of the four decoded opcodes plus deliberately unknown ones, and that every computed data address lies inside the data array. The stimulus meets these assumptions in three ways. It fills both memories before releasing reset. It runs one fixed program whose addresses are all small constants or values loaded from known words. It ends that program in a branch-to-self, so the PC never leaves the loaded region. The operand sweep covers signed extremes and equal pairs, so both branch outcomes and both signs of set-less-than are exercised.

// File: rtl/sc_pkg.sv
package sc_pkg;
   localparam int XLEN = 32;

   typedef enum logic [2:0] {
      ALU_AND = 3'b000,
      ALU_OR  = 3'b001,
      ALU_ADD = 3'b010,
      ALU_SUB = 3'b110,
      ALU_SLT = 3'b111
   } alu_op_e;

   typedef enum logic [1:0] {
      CLS_MEM = 2'b00,
      CLS_BEQ = 2'b01,
      CLS_REG = 2'b10,
      CLS_IMM = 2'b11
   } alu_cls_e;

   localparam logic [5:0] OPC_REG = 6'b000000;
   localparam logic [5:0] OPC_LW  = 6'b100011;
   localparam logic [5:0] OPC_SW  = 6'b101011;
   localparam logic [5:0] OPC_BEQ = 6'b000100;

   localparam logic [5:0] FN_ADD = 6'b100000;
   localparam logic [5:0] FN_SUB = 6'b100010;
   localparam logic [5:0] FN_AND = 6'b100100;
   localparam logic [5:0] FN_OR  = 6'b100101;
   localparam logic [5:0] FN_SLT = 6'b101010;

   typedef struct packed {
      logic     dst_rd;
      logic     reg_we;
      logic     src_imm;
      logic     mem_rd;
      logic     mem_we;
      logic     wb_mem;
      logic     branch;
      alu_cls_e cls;
   } ctrl_t;
endpackage

// File: rtl/sc_main_dec.sv
module sc_main_dec
   import sc_pkg::*;
(
   input  logic [5:0] opcode,
   output ctrl_t      ctl
);
   always_comb begin
      ctl     = '0;
      ctl.cls = CLS_MEM;
      case (opcode)
         OPC_REG: begin
            ctl.dst_rd = 1'b1;
            ctl.reg_we = 1'b1;
            ctl.cls    = CLS_REG;
         end
         OPC_LW: begin
            ctl.reg_we  = 1'b1;
            ctl.src_imm = 1'b1;
            ctl.mem_rd  = 1'b1;
            ctl.wb_mem  = 1'b1;
         end
         OPC_SW: begin
            ctl.src_imm = 1'b1;
            ctl.mem_we  = 1'b1;
         end
         OPC_BEQ: begin
            ctl.branch = 1'b1;
            ctl.cls    = CLS_BEQ;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/sc_alu_dec.sv
module sc_alu_dec
   import sc_pkg::*;
(
   input  alu_cls_e   cls,
   input  logic [5:0] funct,
   output alu_op_e    op
);
   always_comb begin
      op = ALU_ADD;
      case (cls)
         CLS_MEM: op = ALU_ADD;
         CLS_BEQ: op = ALU_SUB;
         CLS_REG: begin
            case (funct)
               FN_ADD:  op = ALU_ADD;
               FN_SUB:  op = ALU_SUB;
               FN_AND:  op = ALU_AND;
               FN_OR:   op = ALU_OR;
               FN_SLT:  op = ALU_SLT;
               default: op = ALU_ADD;
            endcase
         end
         default: op = ALU_ADD;
      endcase
   end
endmodule

// File: rtl/sc_alu.sv
module sc_alu
   import sc_pkg::*;
#(
   parameter int DW = XLEN
) (
   input  alu_op_e         op,
   input  logic [DW-1:0]   a,
   input  logic [DW-1:0]   b,
   output logic [DW-1:0]   y,
   output logic            zero
);
   always_comb begin
      case (op)
         ALU_AND: y = a & b;
         ALU_OR:  y = a | b;
         ALU_SUB: y = a - b;
         ALU_SLT: y = ($signed(a) < $signed(b)) ? DW'(1) : '0;
         default: y = a + b;
      endcase
   end
   assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
   parameter int DW   = 32,
   parameter int NREG = 32,
   localparam int RA_W = $clog2(NREG)
) (
   input  logic            clk,
   input  logic            we,
   input  logic [RA_W-1:0] wa,
   input  logic [DW-1:0]   wd,
   input  logic [RA_W-1:0] ra0,
   input  logic [RA_W-1:0] ra1,
   output logic [DW-1:0]   rd0,
   output logic [DW-1:0]   rd1
);
   logic [DW-1:0] q [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      if (i == 0) begin : g_zero
         assign q[i] = '0;
      end else begin : g_store
         logic [DW-1:0] r;
         always_ff @(posedge clk) begin
            if (we && (wa == RA_W'(i))) r <= wd;
         end
         assign q[i] = r;
      end
   end

   assign rd0 = q[ra0];
   assign rd1 = q[ra1];
endmodule

// File: rtl/sc_ram.sv
module sc_ram #(
   parameter int AW  = 6,
   parameter int DW  = 32,
   parameter int NRD = 1,
   localparam int DEPTH = 1 << AW
) (
   input  logic                     clk,
   input  logic                     we,
   input  logic [AW-1:0]            waddr,
   input  logic [DW-1:0]            wdata,
   input  logic [NRD-1:0][AW-1:0]   raddr,
   output logic [NRD-1:0][DW-1:0]   rdata
);
   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   for (genvar g = 0; g < NRD; g++) begin : g_rd
      assign rdata[g] = mem[raddr[g]];
   end
endmodule

// File: rtl/sc_core.sv
module sc_core
   import sc_pkg::*;
#(
   parameter int IMEM_AW = 6,
   parameter int DMEM_AW = 6,
   localparam int LD_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ld_we,
   input  logic               ld_dmem,
   input  logic [LD_AW-1:0]   ld_addr,
   input  logic [XLEN-1:0]    ld_data,
   input  logic [DMEM_AW-1:0] peek_addr,
   output logic [XLEN-1:0]    peek_data,
   output logic [XLEN-1:0]    pc_o
);
   localparam int NREG = 32;
   localparam int RA_W = $clog2(NREG);

   if (IMEM_AW < 1 || IMEM_AW > 16) begin : g_bad_imem
      $error("sc_core: IMEM_AW out of range");
   end
   if (DMEM_AW < 1 || DMEM_AW > 16) begin : g_bad_dmem
      $error("sc_core: DMEM_AW out of range");
   end
   if (XLEN != 32 || RA_W != 5) begin : g_bad_fmt
      $error("sc_core: instruction format needs 32-bit words and 5-bit register fields");
   end

   // program counter
   logic [XLEN-1:0] pc_q, pc_next, pc_plus4, br_tgt;
   logic            pc_src;

   always_ff @(posedge clk) begin
      if (rst) pc_q <= '0;
      else     pc_q <= pc_next;
   end
   assign pc_o = pc_q;

   // instruction memory
   logic                    im_we;
   logic [0:0][IMEM_AW-1:0] im_ra;
   logic [0:0][XLEN-1:0]    im_rd;
   logic [XLEN-1:0]         instr;

   assign im_we    = rst & ld_we & ~ld_dmem;
   assign im_ra[0] = pc_q[IMEM_AW+1:2];

   sc_ram #(.AW(IMEM_AW), .DW(XLEN), .NRD(1)) u_imem (
      .clk   (clk),
      .we    (im_we),
      .waddr (ld_addr[IMEM_AW-1:0]),
      .wdata (ld_data),
      .raddr (im_ra),
      .rdata (im_rd)
   );
   assign instr = im_rd[0];

   // fields
   logic [5:0]      f_op, f_fn;
   logic [RA_W-1:0] f_rs, f_rt, f_rd;
   logic [15:0]     f_off;
   assign f_op  = instr[31:26];
   assign f_rs  = instr[25:21];
   assign f_rt  = instr[20:16];
   assign f_rd  = instr[15:11];
   assign f_fn  = instr[5:0];
   assign f_off = instr[15:0];

   // control
   ctrl_t   ctl;
   alu_op_e alu_op;

   sc_main_dec u_main_dec (
      .opcode (f_op),
      .ctl    (ctl)
   );

   sc_alu_dec u_alu_dec (
      .cls   (ctl.cls),
      .funct (f_fn),
      .op    (alu_op)
   );

   // register file
   logic            rf_we;
   logic [RA_W-1:0] rf_wa;
   logic [XLEN-1:0] rf_wd, rs_val, rt_val;

   assign rf_we = ctl.reg_we & ~rst;
   assign rf_wa = ctl.dst_rd ? f_rd : f_rt;

   sc_regfile #(.DW(XLEN), .NREG(NREG)) u_rf (
      .clk (clk),
      .we  (rf_we),
      .wa  (rf_wa),
      .wd  (rf_wd),
      .ra0 (f_rs),
      .ra1 (f_rt),
      .rd0 (rs_val),
      .rd1 (rt_val)
   );

   // operands and ALU
   logic [XLEN-1:0] imm_ext, opnd_b, alu_y;
   logic            alu_zero;

   assign imm_ext = {{(XLEN-16){f_off[15]}}, f_off};
   assign opnd_b  = ctl.src_imm ? imm_ext : rt_val;

   sc_alu #(.DW(XLEN)) u_alu (
      .op   (alu_op),
      .a    (rs_val),
      .b    (opnd_b),
      .y    (alu_y),
      .zero (alu_zero)
   );

   // data memory: port 0 core, port 1 peek
   logic                    core_dm_we, dm_we;
   logic [DMEM_AW-1:0]      dm_wa;
   logic [XLEN-1:0]         dm_wd, dm_load;
   logic [1:0][DMEM_AW-1:0] dm_ra;
   logic [1:0][XLEN-1:0]    dm_rd;

   assign core_dm_we = ctl.mem_we & ~rst;
   assign dm_we      = rst ? (ld_we & ld_dmem) : core_dm_we;
   assign dm_wa      = rst ? ld_addr[DMEM_AW-1:0] : alu_y[DMEM_AW+1:2];
   assign dm_wd      = rst ? ld_data : rt_val;
   assign dm_ra[0]   = alu_y[DMEM_AW+1:2];
   assign dm_ra[1]   = peek_addr;

   sc_ram #(.AW(DMEM_AW), .DW(XLEN), .NRD(2)) u_dmem (
      .clk   (clk),
      .we    (dm_we),
      .waddr (dm_wa),
      .wdata (dm_wd),
      .raddr (dm_ra),
      .rdata (dm_rd)
   );

   assign dm_load   = ctl.mem_rd ? dm_rd[0] : '0;
   assign peek_data = dm_rd[1];
   assign rf_wd     = ctl.wb_mem ? dm_load : alu_y;

   // next PC: two separate adders
   assign pc_plus4 = pc_q + XLEN'(4);
   assign br_tgt   = pc_plus4 + (imm_ext << 2);
   assign pc_src   = ctl.branch & alu_zero;
   assign pc_next  = pc_src ? br_tgt : pc_plus4;
endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk
   import sc_pkg::*;
(
   input logic        clk,
   input logic        rst,
   input logic [31:0] pc,
   input logic [31:0] instr,
   input logic        branch,
   input logic        zero,
   input logic        rf_we,
   input logic        dm_we,
   input logic [31:0] rs_val
);
   logic known_op;
   assign known_op = (instr[31:26] == OPC_REG) || (instr[31:26] == OPC_LW) ||
                     (instr[31:26] == OPC_SW)  || (instr[31:26] == OPC_BEQ);

   p_reset_pc_r1: assert property (@(posedge clk) rst |=> (pc == 32'd0));

   p_seq_pc_r6: assert property (@(posedge clk) disable iff (rst)
      !(branch && zero) |=> (pc == $past(pc) + 32'd4));

   p_taken_pc_r10: assert property (@(posedge clk) disable iff (rst)
      (branch && zero) |=> (pc == $past(pc) + 32'd4 +
         {{14{$past(instr[15])}}, $past(instr[15:0]), 2'b00}));

   p_r0_zero_r3: assert property (@(posedge clk) disable iff (rst)
      (instr[25:21] == 5'd0) |-> (rs_val == 32'd0));

   p_store_only_r5: assert property (@(posedge clk) disable iff (rst)
      (instr[31:26] != OPC_SW) |-> !dm_we);

   p_unknown_quiet_r7: assert property (@(posedge clk) disable iff (rst)
      !known_op |-> (!rf_we && !dm_we));
endmodule

bind sc_core sc_core_chk u_chk (
   .clk    (clk),
   .rst    (rst),
   .pc     (pc_q),
   .instr  (instr),
   .branch (ctl.branch),
   .zero   (alu_zero),
   .rf_we  (rf_we),
   .dm_we  (core_dm_we),
   .rs_val (rs_val)
);

// File: tb/sc_core_test.sv
`timescale 1ns/1ps
module sc_core_test;
   localparam int AW = 6;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          ld_we = 1'b0;
   logic          ld_dmem = 1'b0;
   logic [AW-1:0] ld_addr = '0;
   logic [31:0]   ld_data = '0;
   logic [AW-1:0] peek_addr = '0;
   logic [31:0]   peek_data;
   logic [31:0]   pc_o;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   sc_core #(.IMEM_AW(AW), .DMEM_AW(AW)) uut (
      .clk       (clk),
      .rst       (rst),
      .ld_we     (ld_we),
      .ld_dmem   (ld_dmem),
      .ld_addr   (ld_addr),
      .ld_data   (ld_data),
      .peek_addr (peek_addr),
      .peek_data (peek_data),
      .pc_o      (pc_o)
   );

   function automatic logic [31:0] rt_(input int rs, input int rt, input int rd, input logic [5:0] fn);
      return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
   endfunction
   function automatic logic [31:0] it_(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
      return {op, 5'(rs), 5'(rt), imm};
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load(input logic sel, input int addr, input logic [31:0] data);
      @(negedge clk);
      ld_we = 1'b1; ld_dmem = sel; ld_addr = AW'(addr); ld_data = data;
      @(negedge clk);
      ld_we = 1'b0;
   endtask

   task automatic peek(input int addr, output logic [31:0] v);
      peek_addr = AW'(addr);
      #0.5;
      v = peek_data;
   endtask

   logic [31:0] prog [22];
   logic [31:0] vals [8];

   initial begin
      prog[0]  = it_(6'b101011, 0, 0, 16'd60);
      prog[1]  = it_(6'b100011, 0, 1, 16'd0);
      prog[2]  = it_(6'b100011, 0, 2, 16'd4);
      prog[3]  = rt_(1, 2, 3, 6'b100000);
      prog[4]  = it_(6'b101011, 0, 3, 16'd8);
      prog[5]  = rt_(1, 2, 4, 6'b100010);
      prog[6]  = it_(6'b101011, 0, 4, 16'd12);
      prog[7]  = rt_(1, 2, 5, 6'b100100);
      prog[8]  = it_(6'b101011, 0, 5, 16'd16);
      prog[9]  = rt_(1, 2, 6, 6'b100101);
      prog[10] = it_(6'b101011, 0, 6, 16'd20);
      prog[11] = rt_(1, 2, 7, 6'b101010);
      prog[12] = it_(6'b101011, 0, 7, 16'd24);
      prog[13] = rt_(1, 2, 0, 6'b100000);
      prog[14] = it_(6'b101011, 0, 0, 16'd28);
      prog[15] = it_(6'b000100, 1, 2, 16'd1);
      prog[16] = it_(6'b101011, 0, 1, 16'd32);
      prog[17] = it_(6'b001000, 0, 1, 16'd5);
      prog[18] = it_(6'b101011, 0, 1, 16'd36);
      prog[19] = it_(6'b100011, 0, 9, 16'd40);
      prog[20] = it_(6'b101011, 9, 2, 16'hFFFC);
      prog[21] = it_(6'b000100, 0, 0, 16'hFFFF);
      vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
      vals[2] = 32'h0000_0007; vals[3] = 32'hFFFF_FFFF;
      vals[4] = 32'h8000_0000; vals[5] = 32'h7FFF_FFFF;
      vals[6] = 32'h1234_5678; vals[7] = 32'hFFFF_0000;
   end

   initial begin
      logic [31:0] v, a, b;
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            a = vals[i]; b = vals[j];
            @(negedge clk);
            rst = 1'b1;
            for (int k = 0; k < 22; k++) load(1'b0, k, prog[k]);
            load(1'b1, 0, a);
            load(1'b1, 1, b);
            load(1'b1, 8, 32'hFFFF_FFFF);
            load(1'b1, 10, 32'd48);
            load(1'b1, 11, 32'd0);
            load(1'b1, 15, 32'h1234_5678);
            @(negedge clk);
            @(negedge clk);
            check("R1 pc held at zero in reset", pc_o, 32'd0);
            peek(15, v);
            check("R8 core store blocked in reset", v, 32'h1234_5678);
            rst = 1'b0;
            for (int c = 0; c < 30; c++) @(negedge clk);
            check("R6/R10 halt loop on itself", pc_o, 32'd84);
            peek(15, v); check("R5 store word", v, 32'd0);
            peek(2, v);  check("R2 add", v, a + b);
            peek(3, v);  check("R2 sub", v, a - b);
            peek(4, v);  check("R2 and", v, a & b);
            peek(5, v);  check("R2 or", v, a | b);
            peek(6, v);  check("R2 slt signed", v, ($signed(a) < $signed(b)) ? 32'd1 : 32'd0);
            peek(7, v);  check("R3 r0 stays zero", v, 32'd0);
            peek(8, v);  check("R6 beq taken/not taken", v, (a == b) ? 32'hFFFF_FFFF : a);
            peek(9, v);  check("R7 unknown opcode no write", v, a);
            peek(11, v); check("R4/R10 negative offset", v, b);
            peek(0, v);  check("R9 peek port", v, a);
         end
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(150000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule